// File: doc/BRIEF.md
# Binary/BCD add-subtract unit

This block adds with carry or subtracts with borrow. It works on two operands in either plain binary or packed BCD. A decimal mode input picks the number system. A length input picks one of two widths: the full data width, or half of it. In half-width mode only the low half of each operand takes part. The upper half of the result copies operand A's upper half.

In decimal mode every 4-bit digit is corrected inside the unit, so no separate adjust step is needed. The carry output then carries the decimal carry or borrow. Decimal mode has no meaningful zero flag, and a companion output says so. Signed overflow is reported only for binary operations.

The unit registers its result and flags when the start strobe is high. The done strobe pulses in the following cycle. Between operations the registered outputs hold their values.

Top module: `bcd_addsub`

## Requirements
- R1: Binary addition (dec_i=0, sub_i=0): the low W bits of the result are A + B + carry_i, and carry_o is the carry out of bit W-1. W is 16 when byte_i=0 and 8 when byte_i=1.
- R2: Binary subtraction (dec_i=0, sub_i=1): the result is A + ~B + carry_i over W bits. carry_i=1 means no incoming borrow. carry_o=1 means no borrow occurred.
- R3: Decimal addition (dec_i=1, sub_i=0) works digit by digit from nibble 0 upward. The digit sum is a + b + the incoming digit carry. When that sum exceeds 9, 6 is added and a carry passes to the next digit. The digit is the low 4 bits, and carry_o is the carry out of the top digit of the selected width.
- R4: Decimal subtraction (dec_i=1, sub_i=1) works per digit. The difference is a - b - (1 - incoming carry). When it is negative, 6 is subtracted, the digit is the low 4 bits, and the outgoing carry is 0. Otherwise the outgoing carry is 1. carry_o is the carry of the top digit, and 1 means no borrow.
- R5: With byte_i=1 the operation covers bits 7:0 only (2 BCD digits in decimal mode), and res_o[15:8] equals A[15:8]. With byte_i=0 it covers all 16 bits (4 digits).
- R6: neg_o is bit W-1 of the result. zero_o is 1 exactly when result bits W-1:0 are all 0.
- R7: zero_valid_o is 1 after a binary operation and 0 after a decimal operation.
- R8: ovf_o is the signed overflow of the W-bit operation in binary mode. For addition that means A and B have the same sign and the result sign differs. For subtraction it means A and B differ in sign and the result sign differs from A. ovf_o is 0 after any decimal operation.
- R9: The result and flags are captured on the clock edge where start_i=1, and done_o is 1 for exactly the following cycle. Without start_i the outputs keep their values whatever the inputs do.
- R10: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture an operation this cycle |
| sub_i | input | 1 | 1 = subtract with borrow, 0 = add with carry |
| dec_i | input | 1 | 1 = packed BCD, 0 = binary |
| byte_i | input | 1 | 1 = 8-bit operation, 0 = 16-bit operation |
| carry_i | input | 1 | Carry in (for subtraction, 1 = no borrow) |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| res_o | output | 16 | Registered result |
| carry_o | output | 1 | Registered carry / not-borrow |
| neg_o | output | 1 | Registered sign bit of the selected width |
| zero_o | output | 1 | Registered zero flag |
| zero_valid_o | output | 1 | Zero flag is meaningful (binary mode) |
| ovf_o | output | 1 | Registered signed overflow (binary only) |
| done_o | output | 1 | Pulses one cycle after start_i |

## Verification
The assertions check the following on every cycle:
- done_o follows start_i exactly.
- The outputs hold when no start arrives.
- The upper byte passes through unchanged in 8-bit mode.
- After a decimal operation, both zero_valid_o and ovf_o are low.
- Each decimal digit stays in the range 0 to 9 whenever its input digits are valid BCD.

Only the bench's scenarios can show that the arithmetic is right. That covers the decimal corrections rippling across digits, the borrow wrap such as 0000 - 1 giving 9999, signed overflow at the width boundaries, and the zero and negative flags taken from the selected width.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int DIGIT_W = 4;

  typedef struct packed {
    logic carry;
    logic neg;
    logic zero;
    logic zero_valid;
    logic ovf;
  } addsub_flags_t;
endpackage

// File: rtl/addsub_bcd_digit.sv
module addsub_bcd_digit
  import addsub_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_d,
  input  logic [DIGIT_W-1:0] b_d,
  input  logic               cin,
  input  logic               sub,
  output logic [DIGIT_W-1:0] dig,
  output logic               cout
);
  logic [DIGIT_W:0] raw_add;
  logic [DIGIT_W:0] raw_sub;
  logic             adj_add;
  logic             brw;

  always_comb begin
    raw_add = {1'b0, a_d} + {1'b0, b_d} + {{DIGIT_W{1'b0}}, cin};
    raw_sub = {1'b0, a_d} - {1'b0, b_d} - {{DIGIT_W{1'b0}}, ~cin};
    adj_add = raw_add > (DIGIT_W+1)'(9);
    brw     = raw_sub[DIGIT_W];
    if (sub) begin
      dig  = brw ? (raw_sub[DIGIT_W-1:0] - DIGIT_W'(6)) : raw_sub[DIGIT_W-1:0];
      cout = ~brw;
    end else begin
      dig  = adj_add ? (raw_add[DIGIT_W-1:0] + DIGIT_W'(6)) : raw_add[DIGIT_W-1:0];
      cout = adj_add;
    end
  end

  always_comb begin
    if (a_d <= DIGIT_W'(9) && b_d <= DIGIT_W'(9)) begin
      // R3 R4
      digit_range_chk: assert (dig <= DIGIT_W'(9));
    end
  end
endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  input  logic              dec_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int NDIG     = DATA_W / DIGIT_W;
  localparam int HALF_W   = DATA_W / 2;
  localparam int HALF_DIG = NDIG / 2;

  logic [NDIG:0]       dchain;
  logic [DATA_W-1:0]   dres;
  logic [DATA_W-1:0]   b_eff;
  logic [DATA_W:0]     bsum_full;
  logic [HALF_W:0]     bsum_half;
  logic [HALF_W-1:0]   res_lo;
  logic [HALF_W-1:0]   res_hi;

  assign dchain[0] = cin_i;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    addsub_bcd_digit u_dig (
      .a_d  (a_i[g*DIGIT_W +: DIGIT_W]),
      .b_d  (b_i[g*DIGIT_W +: DIGIT_W]),
      .cin  (dchain[g]),
      .sub  (sub_i),
      .dig  (dres[g*DIGIT_W +: DIGIT_W]),
      .cout (dchain[g+1])
    );
  end

  always_comb begin
    b_eff     = sub_i ? ~b_i : b_i;
    bsum_full = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_i};
    bsum_half = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
              + {{HALF_W{1'b0}}, cin_i};
  end

  always_comb begin
    if (dec_i) begin
      res_lo  = dres[HALF_W-1:0];
      carry_o = byte_i ? dchain[HALF_DIG] : dchain[NDIG];
    end else begin
      res_lo  = byte_i ? bsum_half[HALF_W-1:0] : bsum_full[HALF_W-1:0];
      carry_o = byte_i ? bsum_half[HALF_W] : bsum_full[DATA_W];
    end
    if (byte_i)     res_hi = a_i[DATA_W-1:HALF_W];
    else if (dec_i) res_hi = dres[DATA_W-1:HALF_W];
    else            res_hi = bsum_full[DATA_W-1:HALF_W];
    res_o = {res_hi, res_lo};
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  input  logic              a_top_full,
  input  logic              a_top_half,
  input  logic              b_top_full,
  input  logic              b_top_half,
  input  logic              sub_i,
  input  logic              dec_i,
  input  logic              byte_i,
  output addsub_flags_t     flags_o
);
  localparam int HALF_W = DATA_W / 2;

  logic a_s, b_s, r_s;

  always_comb begin
    a_s = byte_i ? a_top_half : a_top_full;
    b_s = byte_i ? b_top_half : b_top_full;
    r_s = byte_i ? res_i[HALF_W-1] : res_i[DATA_W-1];

    flags_o.carry      = carry_i;
    flags_o.neg        = r_s;
    flags_o.zero       = byte_i ? ~|res_i[HALF_W-1:0] : ~|res_i;
    flags_o.zero_valid = ~dec_i;
    if (dec_i)      flags_o.ovf = 1'b0;
    else if (sub_i) flags_o.ovf = (a_s ^ b_s) & (r_s ^ a_s);
    else            flags_o.ovf = ~(a_s ^ b_s) & (r_s ^ a_s);
  end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import addsub_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sub_i,
  input  logic              dec_i,
  input  logic              byte_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic              zero_valid_o,
  output logic              ovf_o,
  output logic              done_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] dp_res;
  logic              dp_carry;
  addsub_flags_t     dp_flags;

  logic [DATA_W-1:0] res_q, res_d;
  addsub_flags_t     flags_q, flags_d;
  logic              done_q, done_d;
  logic              cap_en;

  addsub_datapath #(.DATA_W(DATA_W)) u_dp (
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (carry_i),
    .sub_i   (sub_i),
    .dec_i   (dec_i),
    .byte_i  (byte_i),
    .res_o   (dp_res),
    .carry_o (dp_carry)
  );

  addsub_flags #(.DATA_W(DATA_W)) u_flags (
    .res_i      (dp_res),
    .carry_i    (dp_carry),
    .a_top_full (a_i[DATA_W-1]),
    .a_top_half (a_i[HALF_W-1]),
    .b_top_full (b_i[DATA_W-1]),
    .b_top_half (b_i[HALF_W-1]),
    .sub_i      (sub_i),
    .dec_i      (dec_i),
    .byte_i     (byte_i),
    .flags_o    (dp_flags)
  );

  always_comb begin
    cap_en  = start_i;
    res_d   = res_q;
    flags_d = flags_q;
    done_d  = start_i;
    if (cap_en) begin
      res_d   = dp_res;
      flags_d = dp_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      res_q   <= res_d;
      flags_q <= flags_d;
      done_q  <= done_d;
    end
  end

  assign res_o        = res_q;
  assign carry_o      = flags_q.carry;
  assign neg_o        = flags_q.neg;
  assign zero_o       = flags_q.zero;
  assign zero_valid_o = flags_q.zero_valid;
  assign ovf_o        = flags_q.ovf;
  assign done_o       = done_q;

  // R9
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  // R9
  done_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(res_o) && $stable(carry_o) && $stable(ovf_o));
  // R7
  zero_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> zero_valid_o == !$past(dec_i));
  // R8
  dec_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && dec_i |=> !ovf_o);
  // R5
  upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && byte_i |=> res_o[DATA_W-1:HALF_W] == $past(a_i[DATA_W-1:HALF_W]));
endmodule

// File: tb/test_bcd_addsub.sv
module test_bcd_addsub;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, sub_i, dec_i, byte_i, carry_i;
  logic [15:0] a_i, b_i;
  logic [15:0] res_o;
  logic        carry_o, neg_o, zero_o, zero_valid_o, ovf_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  logic [15:0] m_res;
  logic        m_cy, m_n, m_z, m_zv, m_v, m_done;
  logic        m_dec, m_sub, m_byte;

  always #10 clk = ~clk;

  bcd_addsub i_bcd_addsub (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i), .dec_i(dec_i),
    .byte_i(byte_i), .carry_i(carry_i), .a_i(a_i), .b_i(b_i), .res_o(res_o),
    .carry_o(carry_o), .neg_o(neg_o), .zero_o(zero_o), .zero_valid_o(zero_valid_o),
    .ovf_o(ovf_o), .done_o(done_o)
  );

  function automatic void ref_op(input logic [15:0] a, input logic [15:0] b,
                                 input logic c, input logic sb, input logic dc,
                                 input logic byt, output logic [15:0] res,
                                 output logic cy, output logic n, output logic z,
                                 output logic zv, output logic v);
    int w = byt ? 8 : 16;
    int mask = (1 << w) - 1;
    int r = 0;
    int k = int'(c);
    int as_, bs_, rs_;
    if (!dc) begin
      int bb = sb ? (~int'(b)) & mask : int'(b) & mask;
      int s = (int'(a) & mask) + bb + k;
      r  = s & mask;
      cy = s[w];
      as_ = (int'(a) >> (w-1)) & 1;
      bs_ = (int'(b) >> (w-1)) & 1;
      rs_ = (r >> (w-1)) & 1;
      v = sb ? (as_ != bs_ && rs_ != as_) : (as_ == bs_ && rs_ != as_);
    end else begin
      for (int d = 0; d < w/4; d++) begin
        int ad = (int'(a) >> (4*d)) & 15;
        int bd = (int'(b) >> (4*d)) & 15;
        int t;
        if (!sb) begin
          t = ad + bd + k;
          if (t > 9) begin t = t + 6; k = 1; end else k = 0;
        end else begin
          t = ad - bd - (1 - k);
          if (t < 0) begin t = t - 6; k = 0; end else k = 1;
        end
        r = r | ((t & 15) << (4*d));
      end
      cy = k[0];
      v  = 1'b0;
    end
    res = byt ? ((a & 16'hFF00) | 16'(r)) : 16'(r);
    n   = r[w-1];
    z   = (r == 0);
    zv  = !dc;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_res <= '0; m_cy <= 0; m_n <= 0; m_z <= 0; m_zv <= 0; m_v <= 0; m_done <= 0;
      m_dec <= 0; m_sub <= 0; m_byte <= 0;
    end else begin
      m_done <= start_i;
      if (start_i) begin
        logic [15:0] r; logic cy, n, z, zv, v;
        ref_op(a_i, b_i, carry_i, sub_i, dec_i, byte_i, r, cy, n, z, zv, v);
        m_res <= r; m_cy <= cy; m_n <= n; m_z <= z; m_zv <= zv; m_v <= v;
        m_dec <= dec_i; m_sub <= sub_i; m_byte <= byte_i;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string arith_tag();
    if (!rst_n) return "R10";
    if (m_byte) return "R5";
    if (!m_dec) return m_sub ? "R2" : "R1";
    return m_sub ? "R4" : "R3";
  endfunction

  always @(negedge clk) begin
    if (!finished) begin
      string t = arith_tag();
      chk(res_o === m_res, t, "result", res_o, m_res);
      chk(carry_o === m_cy, t, "carry", 16'(carry_o), 16'(m_cy));
      chk(neg_o === m_n, rst_n ? "R6" : "R10", "neg", 16'(neg_o), 16'(m_n));
      chk(zero_o === m_z, rst_n ? "R6" : "R10", "zero", 16'(zero_o), 16'(m_z));
      chk(zero_valid_o === m_zv, rst_n ? "R7" : "R10", "zero_valid",
          16'(zero_valid_o), 16'(m_zv));
      chk(ovf_o === m_v, rst_n ? "R8" : "R10", "ovf", 16'(ovf_o), 16'(m_v));
      chk(done_o === m_done, rst_n ? "R9" : "R10", "done", 16'(done_o), 16'(m_done));
    end
  end

  task automatic op(input logic [15:0] a, input logic [15:0] b, input logic c,
                    input logic sb, input logic dc, input logic byt);
    @(negedge clk);
    a_i = a; b_i = b; carry_i = c; sub_i = sb; dec_i = dc; byte_i = byt;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      a_i = 16'($urandom); b_i = 16'($urandom);
      sub_i = 1'($urandom); dec_i = 1'($urandom); byte_i = 1'($urandom);
      carry_i = 1'($urandom);
    end
  endtask

  function automatic logic [15:0] rand_bcd();
    logic [15:0] v;
    for (int d = 0; d < 4; d++) v[4*d +: 4] = 4'($urandom_range(0, 9));
    return v;
  endfunction

  initial begin
    rst_n = 1'b0; start_i = 0; sub_i = 0; dec_i = 0; byte_i = 0; carry_i = 0;
    a_i = 16'h5555; b_i = 16'hAAAA;
    // R10: reset holds outputs at zero even with start raised
    repeat (2) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    rst_n = 1'b1;
    // R1 binary add
    op(16'h1234, 16'h4321, 0, 0, 0, 0);
    op(16'hFFFF, 16'h0000, 1, 0, 0, 0);   // carry out, zero (R6)
    op(16'h7FFF, 16'h0001, 0, 0, 0, 0);   // R8 overflow
    // R2 binary subtract
    op(16'h0000, 16'h0001, 1, 1, 0, 0);   // borrow, FFFF
    op(16'h8000, 16'h0001, 1, 1, 0, 0);   // R8 overflow
    op(16'h5000, 16'h1000, 0, 1, 0, 0);
    // R5 byte mode
    op(16'h12FF, 16'h0001, 0, 0, 0, 1);   // upper passes, zero, carry
    op(16'hAB7F, 16'h0001, 0, 0, 0, 1);   // 8-bit overflow
    op(16'hCD00, 16'h0001, 1, 1, 0, 1);
    // R3 decimal add
    op(16'h0099, 16'h0001, 0, 0, 1, 1);
    op(16'h9999, 16'h0001, 0, 0, 1, 0);
    op(16'h0458, 16'h0367, 1, 0, 1, 0);
    // R4 decimal subtract
    op(16'h0000, 16'h0001, 1, 1, 1, 0);   // 9999, borrow
    op(16'h5000, 16'h2501, 1, 1, 1, 0);
    op(16'h3410, 16'h0011, 0, 1, 1, 1);
    // R9 hold while inputs move
    idle(5);
    for (int i = 0; i < 300; i++) begin
      logic dc = 1'($urandom);
      logic [15:0] a = dc ? rand_bcd() : 16'($urandom);
      logic [15:0] b = dc ? rand_bcd() : 16'($urandom);
      op(a, b, 1'($urandom), 1'($urandom), dc, 1'($urandom));
      if (i % 7 == 0) idle(2);
    end
    // R10 mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    op(16'h0001, 16'h0001, 0, 0, 0, 0);
    idle(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule